// File: doc/BRIEF.md
# Merged Instruction Control Decoder

This block is the control unit of a 32-bit processor that finishes each instruction in one clock cycle. It reads the 6-bit primary opcode, the 6-bit function field of register-format instructions and the zero flag from the ALU. From these it drives every control line the datapath needs: register-file write, destination choice, ALU second-operand choice, memory write, load-result routing, jump, the next-PC branch choice, immediate sign extension and a 5-bit structured ALU function code.

The decoder is purely combinational. Opcode decoding and function-field decoding sit in one merged unit, and no intermediate ALU-op code passes between them. The function code has the fields {subtract, boolean[1:0], shift, math}, and the decoder produces it straight from the instruction bits. Both the equal branch and the not-equal branch are resolved inside the block from the zero flag, so the datapath only has to apply `pc_branch` to its next-PC multiplexer.

Any opcode the decoder does not recognise is turned into a harmless no-operation. The same applies to an unrecognised function code under the register-format opcode. In a no-operation no state can change and the PC simply advances.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 000000 and a known function field, the outputs are `reg_we`=1, `dst_rd`=1, `b_imm`=0, `mem_we`=0, `mem_to_reg`=0, `jump`=0, `pc_branch`=0 and `sext_en`=0. `alu_fn` depends on the function field: 100000 gives 00001 (add), 100010 gives 10001 (subtract), 100100 gives 00000 (AND), 100101 gives 00100 (OR) and 101010 gives 10011 (signed less-than).
- R2: Opcode 100011 (load word) gives `reg_we`=1, `dst_rd`=0, `b_imm`=1, `mem_to_reg`=1, `mem_we`=0 and `alu_fn`=00001.
- R3: Opcode 101011 (store word) gives `mem_we`=1, `b_imm`=1, `reg_we`=0 and `alu_fn`=00001.
- R4: Opcode 001000 (add immediate) gives `reg_we`=1, `dst_rd`=0, `b_imm`=1, `mem_to_reg`=0 and `alu_fn`=00001.
- R5: Opcodes 001100 (AND immediate) and 001101 (OR immediate) give `reg_we`=1, `dst_rd`=0 and `b_imm`=1. `alu_fn` is 00000 for 001100 and 00100 for 001101.
- R6: Opcode 000010 (jump) sets `jump`=1 and leaves every other enable at 0.
- R7: Opcode 000100 drives `pc_branch` equal to `zero_flag`. Opcode 000101 drives `pc_branch` equal to NOT `zero_flag`. Both give `alu_fn`=10001, `b_imm`=0 and no writes.
- R8: `sext_en` is 1 only for opcodes 001000, 100011, 101011, 000100 and 000101. It is 0 for the logical immediates and for all other opcodes.
- R9: Any other opcode gives a no-operation: every output bit is 0 except `alu_fn`, which is 00001.
- R10: Opcode 000000 with any function field other than the five in R1 gives the same no-operation as R9.
- R11: The outputs follow the inputs with no register stage. A change of input is visible in the same cycle.
- R12: `pc_branch` is never 1 for an opcode other than the two branches, whatever the value of `zero_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, used when the opcode is 000000 |
| zero_flag | input | 1 | ALU result-is-zero flag |
| reg_we | output | 1 | Register-file write enable |
| dst_rd | output | 1 | 1: write the rd field register, 0: write rt |
| b_imm | output | 1 | 1: ALU operand B is the extended immediate |
| mem_we | output | 1 | Data-memory write enable |
| mem_to_reg | output | 1 | 1: register write data comes from memory |
| jump | output | 1 | Take the jump target |
| pc_branch | output | 1 | Take the branch target |
| sext_en | output | 1 | 1: sign-extend the immediate, 0: zero-extend |
| alu_fn | output | 5 | ALU function {sub, bool[1:0], shift, math} |

## Verification
The bench sweeps all opcodes against all function values with both zero-flag levels. This exposes a decoder that wrongly treats a neighbouring opcode as a known instruction, or that lets an unknown function field write the register file, which would silently corrupt architectural state. The branch cases go after a swapped or missing inversion of the zero flag, which would make the not-equal branch behave like the equal one. They also catch a branch select that leaks into non-branch opcodes and would send the PC off on ordinary loads. The logical immediates are checked for zero extension, because sign extension there would flip the upper half of masks.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 5;

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [FN_W-1:0]  fn_t;
    typedef logic [ALU_W-1:0] alu_fn_t;

    // ALU function fields: {sub, bool[1:0], shift, math}
    localparam alu_fn_t ALU_ADD = 5'b0_00_0_1;
    localparam alu_fn_t ALU_SUB = 5'b1_00_0_1;
    localparam alu_fn_t ALU_SLT = 5'b1_00_1_1;
    localparam alu_fn_t ALU_AND = 5'b0_00_0_0;
    localparam alu_fn_t ALU_OR  = 5'b0_01_0_0;

    localparam op_t OPC_RTYPE = 6'b000000;
    localparam op_t OPC_JMP   = 6'b000010;
    localparam op_t OPC_BEQ   = 6'b000100;
    localparam op_t OPC_BNE   = 6'b000101;
    localparam op_t OPC_ADDI  = 6'b001000;
    localparam op_t OPC_ANDI  = 6'b001100;
    localparam op_t OPC_ORI   = 6'b001101;
    localparam op_t OPC_LOAD  = 6'b100011;
    localparam op_t OPC_STORE = 6'b101011;

    localparam fn_t FNC_ADD = 6'b100000;
    localparam fn_t FNC_SUB = 6'b100010;
    localparam fn_t FNC_AND = 6'b100100;
    localparam fn_t FNC_OR  = 6'b100101;
    localparam fn_t FNC_SLT = 6'b101010;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_t;

    typedef struct packed {
        logic     reg_we;
        logic     dst_rd;
        logic     b_imm;
        logic     mem_we;
        logic     mem_to_reg;
        logic     jump;
        logic     sext_en;
        logic     is_rtype;
        br_kind_t br;
        alu_fn_t  fn;
    } ctl_t;

    function automatic ctl_t ctl_nop();
        ctl_t c;
        c          = '0;
        c.br       = BR_NONE;
        c.fn       = ALU_ADD;
        return c;
    endfunction

endpackage

// File: rtl/ctl_op_dec.sv
module ctl_op_dec
    import ctl_pkg::*;
(
    input  op_t  opcode,
    output ctl_t ctl
);
    always_comb begin
        ctl = ctl_nop();
        unique case (opcode)
            OPC_RTYPE: begin
                ctl.reg_we   = 1'b1;
                ctl.dst_rd   = 1'b1;
                ctl.is_rtype = 1'b1;
            end
            OPC_LOAD: begin
                ctl.reg_we     = 1'b1;
                ctl.b_imm      = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.sext_en    = 1'b1;
            end
            OPC_STORE: begin
                ctl.mem_we  = 1'b1;
                ctl.b_imm   = 1'b1;
                ctl.sext_en = 1'b1;
            end
            OPC_ADDI: begin
                ctl.reg_we  = 1'b1;
                ctl.b_imm   = 1'b1;
                ctl.sext_en = 1'b1;
            end
            OPC_ANDI: begin
                ctl.reg_we = 1'b1;
                ctl.b_imm  = 1'b1;
                ctl.fn     = ALU_AND;
            end
            OPC_ORI: begin
                ctl.reg_we = 1'b1;
                ctl.b_imm  = 1'b1;
                ctl.fn     = ALU_OR;
            end
            OPC_BEQ: begin
                ctl.br      = BR_EQ;
                ctl.sext_en = 1'b1;
                ctl.fn      = ALU_SUB;
            end
            OPC_BNE: begin
                ctl.br      = BR_NE;
                ctl.sext_en = 1'b1;
                ctl.fn      = ALU_SUB;
            end
            OPC_JMP: begin
                ctl.jump = 1'b1;
            end
            default: ;
        endcase
    end

    // Stores never write the register file (R3)
    always_comb begin
        if (!$isunknown(ctl))
            p_store_no_regwr_r3: assert (!(ctl.mem_we && ctl.reg_we))
                else $error("store also writes register file");
    end

    // Logical immediates zero-extend (R8)
    always_comb begin
        if (!$isunknown(opcode))
            p_logic_zext_r8: assert (!((opcode == OPC_ANDI || opcode == OPC_ORI) && ctl.sext_en))
                else $error("logical immediate sign-extended");
    end
endmodule

// File: rtl/ctl_fn_dec.sv
module ctl_fn_dec
    import ctl_pkg::*;
(
    input  fn_t     funct,
    output logic    known,
    output alu_fn_t fn
);
    always_comb begin
        known = 1'b1;
        fn    = ALU_ADD;
        unique case (funct)
            FNC_ADD: fn = ALU_ADD;
            FNC_SUB: fn = ALU_SUB;
            FNC_AND: fn = ALU_AND;
            FNC_OR:  fn = ALU_OR;
            FNC_SLT: fn = ALU_SLT;
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_br_res.sv
module ctl_br_res
    import ctl_pkg::*;
(
    input  br_kind_t br,
    input  logic     zero_flag,
    output logic     take
);
    always_comb begin
        unique case (br)
            BR_EQ:   take = zero_flag;
            BR_NE:   take = ~zero_flag;
            default: take = 1'b0;
        endcase
    end

    // No branch kind, no redirect (R12)
    always_comb begin
        if (!$isunknown({br, zero_flag}))
            p_no_stray_branch_r12: assert (!(take && br == BR_NONE))
                else $error("branch taken without branch opcode");
    end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       zero_flag,
    output logic       reg_we,
    output logic       dst_rd,
    output logic       b_imm,
    output logic       mem_we,
    output logic       mem_to_reg,
    output logic       jump,
    output logic       pc_branch,
    output logic       sext_en,
    output logic [4:0] alu_fn
);
    ctl_t    op_ctl;
    ctl_t    fin;
    logic    fn_known;
    alu_fn_t fn_code;
    logic    br_take;

    ctl_op_dec u_op (.opcode(opcode), .ctl(op_ctl));
    ctl_fn_dec u_fn (.funct(funct), .known(fn_known), .fn(fn_code));
    ctl_br_res u_br (.br(fin.br), .zero_flag(zero_flag), .take(br_take));

    always_comb begin
        fin = op_ctl;
        if (op_ctl.is_rtype) begin
            if (fn_known) fin.fn = fn_code;
            else          fin    = ctl_nop();
        end
    end

    assign reg_we     = fin.reg_we;
    assign dst_rd     = fin.dst_rd;
    assign b_imm      = fin.b_imm;
    assign mem_we     = fin.mem_we;
    assign mem_to_reg = fin.mem_to_reg;
    assign jump       = fin.jump;
    assign sext_en    = fin.sext_en;
    assign alu_fn     = fin.fn;
    assign pc_branch  = br_take;

    // Jump is exclusive of every other enable (R6)
    always_comb begin
        if (!$isunknown({jump, reg_we, mem_we, pc_branch}))
            p_jump_alone_r6: assert (!(jump && (reg_we || mem_we || pc_branch)))
                else $error("jump with other enables");
    end

    // Branch redirect only from branch opcodes (R7)
    always_comb begin
        if (!$isunknown({opcode, pc_branch}))
            p_branch_src_r7: assert (!pc_branch || opcode == OPC_BEQ || opcode == OPC_BNE)
                else $error("pc_branch from non-branch opcode");
    end

    // Unknown funct under register format is a no-op (R10)
    always_comb begin
        if (!$isunknown({opcode, fn_known, reg_we, dst_rd}))
            p_rtype_unknown_nop_r10: assert (!(opcode == OPC_RTYPE && !fn_known && (reg_we || dst_rd)))
                else $error("unknown funct writes");
    end
endmodule

// File: tb/test_ctl_decoder.sv
module test_ctl_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero_flag = 1'b0;
    logic       reg_we, dst_rd, b_imm, mem_we, mem_to_reg, jump, pc_branch, sext_en;
    logic [4:0] alu_fn;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ctl_decoder i_ctl_decoder (
        .opcode(opcode), .funct(funct), .zero_flag(zero_flag),
        .reg_we(reg_we), .dst_rd(dst_rd), .b_imm(b_imm), .mem_we(mem_we),
        .mem_to_reg(mem_to_reg), .jump(jump), .pc_branch(pc_branch),
        .sext_en(sext_en), .alu_fn(alu_fn)
    );

    // Reference: {reg_we,dst_rd,b_imm,mem_we,mem_to_reg,jump,pc_branch,sext_en,alu_fn}
    function automatic logic [12:0] model(input int op, input int fn, input bit z);
        logic [12:0] r;
        r = {8'b0, 5'b00001};
        if (op == 0) begin
            if (fn == 32)      r = {8'b11000000, 5'b00001};
            else if (fn == 34) r = {8'b11000000, 5'b10001};
            else if (fn == 36) r = {8'b11000000, 5'b00000};
            else if (fn == 37) r = {8'b11000000, 5'b00100};
            else if (fn == 42) r = {8'b11000000, 5'b10011};
        end
        else if (op == 35) r = {8'b10101001, 5'b00001};
        else if (op == 43) r = {8'b00110001, 5'b00001};
        else if (op == 8)  r = {8'b10100001, 5'b00001};
        else if (op == 12) r = {8'b10100000, 5'b00000};
        else if (op == 13) r = {8'b10100000, 5'b00100};
        else if (op == 2)  r = {8'b00000100, 5'b00001};
        else if (op == 4)  r = {6'b0, z, 1'b1, 5'b10001};
        else if (op == 5)  r = {6'b0, ~z, 1'b1, 5'b10001};
        return r;
    endfunction

    function automatic string tag(input int op, input int fn);
        case (op)
            0:  return (fn==32||fn==34||fn==36||fn==37||fn==42) ? "R1" : "R10";
            35: return "R2";
            43: return "R3";
            8:  return "R4";
            12, 13: return "R5";
            2:  return "R6";
            4, 5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req);
        logic [12:0] got, exp;
        got = {reg_we, dst_rd, b_imm, mem_we, mem_to_reg, jump, pc_branch, sext_en, alu_fn};
        exp = model(int'(opcode), int'(funct), zero_flag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b",
                     req, opcode, funct, zero_flag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 30000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: op 0, funct 0 is unknown -> no-op (R10)
        @(negedge clk);
        compare("R10");
        // Exhaustive sweep; R8 and R12 covered by the full-vector compare
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                for (int z = 0; z < 2; z++) begin
                    @(posedge clk);
                    opcode    = 6'(op);
                    funct     = 6'(fn);
                    zero_flag = z[0];
                    @(negedge clk);
                    compare(tag(op, fn));
                end
            end
        end
        // R11: same-cycle response to input change without a clock edge
        @(negedge clk);
        opcode = 6'b000000; funct = 6'b100010; #1;
        compare("R11");
        funct = 6'b101010; #1;
        compare("R11");
        opcode = 6'b000101; zero_flag = 1'b1; #1;
        compare("R11");
        zero_flag = 1'b0; #1;
        compare("R11");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule